// File: doc/BRIEF.md
# Power Mode Clock-Gating Controller

This block decides the power state of a small processor subsystem and drives the clock and oscillator enables that follow from it. Software issues a power-save command whose one-bit operand selects a deep state (Sleep) or a light state (Idle). In Idle only the CPU clock is gated. In Sleep the main oscillator is switched off, so both the CPU and the peripheral clocks stop. The clock monitor is held off, and the low-power oscillator keeps running only for an enabled watchdog.

The block leaves a low-power state when an enabled interrupt is pending, when the watchdog times out, or on reset. Leaving Sleep first turns the main oscillator back on. The CPU clock stays gated until the oscillator reports that it is ready. The selected clock source is held in a register that can only be written in Run, so the subsystem wakes on the same source it slept on.

The command port uses valid/ready. `cmd_ready` is high only in Run. While it is low, a pending command is simply not taken and the requester holds `cmd_valid`. A command is accepted in a cycle where both are high. All other pins are plain level signals.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low puts the block in Run. In Run, `mode` = 2'b00, the CPU, peripheral and main-oscillator enables are 1, `wdt_clr` is 0, `cmd_ready` is 1 and `clk_src` equals the parameter `SRC_RST` (default 1).
- R2: `cmd_ready` is 1 only in Run. A command presented while `cmd_ready` is 0 has no effect on the state.
- R3: An accepted command with `cmd_op` = 0 gives `mode` = 2'b10 (Sleep) from the next edge. In Sleep the CPU clock, peripheral clock and main-oscillator enables are all 0.
- R4: An accepted command with `cmd_op` = 1 gives `mode` = 2'b01 (Idle) from the next edge. In Idle the CPU clock enable is 0, while the peripheral clock and main-oscillator enables are 1.
- R5: A wake event is either a bit set in both `irq_pend` and `irq_en`, or `wdt_timeout` high. A pending interrupt whose `irq_en` bit is 0 does not wake the block.
- R6: A wake event in Idle returns the block to Run at the next edge.
- R7: A wake event in Sleep sets the main-oscillator enable at the next edge. `mode` stays 2'b10 and the CPU clock stays gated while `osc_ready` is 0. Run, with the CPU clock enable at 1, starts at the edge after `osc_ready` is first seen high.
- R8: `wdt_clr` is high for exactly the cycle in which a Sleep command is accepted, and only when `wdt_en` is 1. An Idle command never raises it.
- R9: `lp_osc_en` follows `wdt_en` in Sleep, including the oscillator wait. It is 1 in Run and Idle.
- R10: `clkmon_en` is 0 throughout Sleep, including the oscillator wait. It equals `mon_cfg_en` in Run and Idle.
- R11: `clk_src` loads `src_sel_in` at an edge where `src_sel_we` is high in Run. Writes in any other state are dropped, so the source in use before Sleep is still present after wake.
- R12: Reset taken from Sleep or Idle returns the block to Run at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Power-save command present |
| cmd_ready | output | 1 | Command can be taken (Run only) |
| cmd_op | input | 1 | 0 = Sleep, 1 = Idle |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Per-line wake enables |
| wdt_en | input | 1 | Watchdog is enabled |
| wdt_timeout | input | 1 | Watchdog expired |
| osc_ready | input | 1 | Main oscillator stable |
| mon_cfg_en | input | 1 | Clock monitor configured on |
| src_sel_we | input | 1 | Write strobe for clock source |
| src_sel_in | input | SRC_W | New clock source code |
| mode | output | 2 | 00 Run, 01 Idle, 10 Sleep |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| main_osc_en | output | 1 | Main oscillator enable |
| lp_osc_en | output | 1 | Low-power oscillator enable |
| clkmon_en | output | 1 | Fail-safe clock monitor enable |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| clk_src | output | SRC_W | Held clock source selection |

## Verification
A vector sequence runs the block through Idle and then Sleep. It mixes enabled and masked interrupt patterns, and shows that only a line with both pend and enable set wakes the block. A command offered outside Run tests the back-pressure rule. Driving `osc_ready` high before any wake event, and then holding it low after the wake, separates the oscillator wait from plain Sleep. Directed cases toggle `wdt_en` inside Sleep, write the clock source in Run and in Sleep, and reset from Sleep, to show which inputs reach the outputs in each state.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_SLEEP = 2'b10
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_RUN     = 2'b00,
    ST_IDLE    = 2'b01,
    ST_SLEEP   = 2'b10,
    ST_OSCWAIT = 2'b11
  } pwr_state_e;

  localparam logic OP_SLEEP = 1'b0;
  localparam logic OP_IDLE  = 1'b1;
endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
  parameter int NUM_IRQ = 4
) (
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               wdt_timeout,
  output logic               wake
);
  logic [NUM_IRQ-1:0] armed;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign armed[i] = irq_pend[i] & irq_en[i];
  end

  assign wake = (|armed) | wdt_timeout;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic       cmd_op,
  input  logic       wake,
  input  logic       osc_ready,
  input  logic       wdt_en,
  output pwr_state_e state,
  output logic       cmd_ready,
  output logic       wdt_clr
);
  pwr_state_e next_state;
  logic       cmd_fire;

  assign cmd_ready = (state == ST_RUN);
  assign cmd_fire  = cmd_valid & cmd_ready;
  assign wdt_clr   = cmd_fire & (cmd_op == OP_SLEEP) & wdt_en;

  always_comb begin
    next_state = state;
    unique case (state)
      ST_RUN:     if (cmd_fire) next_state = (cmd_op == OP_SLEEP) ? ST_SLEEP : ST_IDLE;
      ST_IDLE:    if (wake) next_state = ST_RUN;
      ST_SLEEP:   if (wake) next_state = ST_OSCWAIT;
      ST_OSCWAIT: if (osc_ready) next_state = ST_RUN;
      default:    next_state = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= next_state;
  end

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_SLEEP |=> state == ST_SLEEP);

  // R5
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SLEEP && !wake |=> state == ST_SLEEP);

  // R7
  oscwait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_OSCWAIT && !osc_ready |=> state == ST_OSCWAIT);

  // R8
  wdt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_clr);
endmodule

// File: rtl/pwr_clk_decode.sv
module pwr_clk_decode
  import pwr_mode_pkg::*;
#(
  parameter int               SRC_W   = 3,
  parameter logic [SRC_W-1:0] SRC_RST = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwr_state_e       state,
  input  logic             wdt_en,
  input  logic             mon_cfg_en,
  input  logic             src_sel_we,
  input  logic [SRC_W-1:0] src_sel_in,
  output logic [1:0]       mode,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             main_osc_en,
  output logic             lp_osc_en,
  output logic             clkmon_en,
  output logic [SRC_W-1:0] clk_src
);
  logic in_sleep;

  assign in_sleep = (state == ST_SLEEP) | (state == ST_OSCWAIT);

  always_ff @(posedge clk) begin
    if (!rst_n)                           clk_src <= SRC_RST;
    else if (state == ST_RUN && src_sel_we) clk_src <= src_sel_in;
  end

  always_comb begin
    unique case (state)
      ST_RUN:  mode = MODE_RUN;
      ST_IDLE: mode = MODE_IDLE;
      default: mode = MODE_SLEEP;
    endcase
    cpu_clk_en  = (state == ST_RUN);
    per_clk_en  = (state == ST_RUN) | (state == ST_IDLE);
    main_osc_en = (state != ST_SLEEP);
    lp_osc_en   = in_sleep ? wdt_en : 1'b1;
    clkmon_en   = in_sleep ? 1'b0 : mon_cfg_en;
  end

  // R11
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_RUN |=> $stable(clk_src));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int               NUM_IRQ = 4,
  parameter int               SRC_W   = 3,
  parameter logic [SRC_W-1:0] SRC_RST = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_op,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               wdt_en,
  input  logic               wdt_timeout,
  input  logic               osc_ready,
  input  logic               mon_cfg_en,
  input  logic               src_sel_we,
  input  logic [SRC_W-1:0]   src_sel_in,
  output logic [1:0]         mode,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               main_osc_en,
  output logic               lp_osc_en,
  output logic               clkmon_en,
  output logic               wdt_clr,
  output logic [SRC_W-1:0]   clk_src
);
  logic       wake;
  pwr_state_e state;

  pwr_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_wake (
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .wdt_timeout (wdt_timeout),
    .wake        (wake)
  );

  pwr_state_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wake      (wake),
    .osc_ready (osc_ready),
    .wdt_en    (wdt_en),
    .state     (state),
    .cmd_ready (cmd_ready),
    .wdt_clr   (wdt_clr)
  );

  pwr_clk_decode #(.SRC_W(SRC_W), .SRC_RST(SRC_RST)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .wdt_en      (wdt_en),
    .mon_cfg_en  (mon_cfg_en),
    .src_sel_we  (src_sel_we),
    .src_sel_in  (src_sel_in),
    .mode        (mode),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .main_osc_en (main_osc_en),
    .lp_osc_en   (lp_osc_en),
    .clkmon_en   (clkmon_en),
    .clk_src     (clk_src)
  );

  // R4
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_IDLE |-> per_clk_en && !cpu_clk_en && main_osc_en);

  // R6
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == MODE_IDLE && wake |=> mode == MODE_RUN && cpu_clk_en);

  // R3
  sleep_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_op |=> !main_osc_en && !per_clk_en);
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_op = 1'b0;
  logic [3:0] irq_pend = '0, irq_en = '0;
  logic       wdt_en = 1'b1, wdt_timeout = 1'b0, osc_ready = 1'b0;
  logic       mon_cfg_en = 1'b1, src_sel_we = 1'b0;
  logic [2:0] src_sel_in = '0;
  logic       cmd_ready, cpu_clk_en, per_clk_en, main_osc_en, lp_osc_en, clkmon_en, wdt_clr;
  logic [1:0] mode;
  logic [2:0] clk_src;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .irq_pend(irq_pend), .irq_en(irq_en), .wdt_en(wdt_en), .wdt_timeout(wdt_timeout),
    .osc_ready(osc_ready), .mon_cfg_en(mon_cfg_en), .src_sel_we(src_sel_we),
    .src_sel_in(src_sel_in), .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .main_osc_en(main_osc_en), .lp_osc_en(lp_osc_en), .clkmon_en(clkmon_en),
    .wdt_clr(wdt_clr), .clk_src(clk_src)
  );

  // fields: cv op pend[4] en[4] wto ordy | mode[2] cpu per osc clr rdy
  localparam logic [18:0] VEC [16] = '{
    19'b0_0_0000_0000_0_0_00_1_1_1_0_1,  // R1 run after reset
    19'b1_1_0000_0000_0_0_00_1_1_1_0_1,  // R4 idle command, R8 no clear
    19'b0_0_0000_0000_0_0_01_0_1_1_0_0,  // R4 idle gating
    19'b0_0_0001_0000_0_0_01_0_1_1_0_0,  // R5 masked line
    19'b1_0_0000_0000_0_0_01_0_1_1_0_0,  // R2 command refused
    19'b0_0_0100_0100_0_0_01_0_1_1_0_0,  // R6 enabled line wakes
    19'b0_0_0000_0000_0_0_00_1_1_1_0_1,  // R6 back in run
    19'b1_0_0000_0000_0_0_00_1_1_1_1_1,  // R8 clear pulse on sleep accept
    19'b0_0_0000_0000_0_0_10_0_0_0_0_0,  // R3 sleep gating
    19'b0_0_1000_0111_0_0_10_0_0_0_0_0,  // R5 pend without enable
    19'b0_0_0000_0000_0_1_10_0_0_0_0_0,  // R7 ready alone does not wake
    19'b0_0_0000_0000_1_0_10_0_0_0_0_0,  // R5 watchdog timeout wakes
    19'b0_0_0000_0000_0_0_10_0_0_1_0_0,  // R7 oscillator wait
    19'b0_0_0000_0000_0_1_10_0_0_1_0_0,  // R7 ready seen
    19'b0_0_0000_0000_0_0_00_1_1_1_0_1,  // R7 run after ready
    19'b1_0_0000_0000_0_0_00_1_1_1_1_1   // R3 sleep again
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic quiet();
    cmd_valid = 0; cmd_op = 0; irq_pend = '0; irq_en = '0;
    wdt_timeout = 0; osc_ready = 0; src_sel_we = 0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 mode", mode, 2'b00);
    chk("R1 cpu", cpu_clk_en, 1);
    chk("R1 src", clk_src, 3'd1);
    chk("R1 ready", cmd_ready, 1);

    for (int i = 0; i < 16; i++) begin
      step();
      {cmd_valid, cmd_op, irq_pend, irq_en, wdt_timeout, osc_ready} = VEC[i][18:7];
      #1;
      chk($sformatf("R2-vec%0d mode", i), mode, VEC[i][6:5]);
      chk($sformatf("R3 vec%0d cpu", i), cpu_clk_en, VEC[i][4]);
      chk($sformatf("R4 vec%0d per", i), per_clk_en, VEC[i][3]);
      chk($sformatf("R7 vec%0d osc", i), main_osc_en, VEC[i][2]);
      chk($sformatf("R8 vec%0d clr", i), wdt_clr, VEC[i][1]);
      chk($sformatf("R2 vec%0d ready", i), cmd_ready, VEC[i][0]);
    end

    // now in Sleep
    step(); quiet(); #1;
    chk("R9 lp osc with watchdog", lp_osc_en, 1);
    chk("R10 monitor off in sleep", clkmon_en, 0);
    wdt_en = 0; #1;
    chk("R9 lp osc without watchdog", lp_osc_en, 0);
    src_sel_we = 1; src_sel_in = 3'd5;
    step(); src_sel_we = 0; #1;
    chk("R11 write dropped in sleep", clk_src, 3'd1);
    rst_n = 0;
    step(); #1;
    chk("R12 reset from sleep mode", mode, 2'b00);
    chk("R12 reset from sleep cpu", cpu_clk_en, 1);
    rst_n = 1;
    chk("R10 monitor follows cfg in run", clkmon_en, 1);
    src_sel_we = 1; src_sel_in = 3'd5;
    step(); src_sel_we = 0; #1;
    chk("R11 write in run", clk_src, 3'd5);
    cmd_valid = 1; cmd_op = 0; #1;
    chk("R8 no clear with watchdog off", wdt_clr, 0);
    step(); quiet(); src_sel_we = 1; src_sel_in = 3'd2;
    step(); quiet(); irq_pend = 4'b0001; irq_en = 4'b0001;
    step(); quiet(); #1;
    chk("R7 wait mode", mode, 2'b10);
    chk("R10 monitor off in wait", clkmon_en, 0);
    osc_ready = 1;
    step(); quiet(); #1;
    chk("R7 run after wake", mode, 2'b00);
    chk("R11 source kept over sleep", clk_src, 3'd5);
    wdt_en = 1; cmd_valid = 1; cmd_op = 1; #1;
    chk("R8 no clear on idle command", wdt_clr, 0);
    step(); quiet(); #1;
    chk("R4 idle mode", mode, 2'b01);
    chk("R10 monitor on in idle", clkmon_en, 1);
    chk("R9 lp osc in idle", lp_osc_en, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule